// File: doc/BRIEF.md
# Two-Level Next-Fetch Address Table

This block sits beside the instruction fetch stage of a wide-issue core. Each entry is tied to one fetch address. It holds the addresses of the two basic blocks that can follow a first branch, and of the four blocks that can follow a second branch on either side. The first branch is the one that ends the current fetch group; the second is the one that ends whichever successor block is reached. Given the current fetch address and two direction predictions, the table returns the next two fetch addresses in one lookup. The fetch unit can then supply three consecutive basic blocks without knowing where the later branches sit.

Each entry has a tag and three branch descriptors. The descriptors are: the first branch, the branch at the end of the taken-side block, and the branch at the end of the fall-through-side block. Each descriptor carries a valid bit and a 2-bit kind. Each entry also holds six word addresses. An unconditional kind ignores the prediction and always goes taken. Where no branch was recorded, the answer falls back to the next sequential fetch group. A write port installs or replaces a whole entry at once.

Lookup is registered. The address and predictions presented before a rising edge produce results that are valid after that edge.

Top module: `bac_lookup`

## Requirements
- R1: After reset every entry is empty; while reset is held, and for every lookup until the first fill, `hit` is 0.
- R2: A lookup whose address was filled at an earlier edge returns `hit`=1, with all outputs valid one clock after the address is sampled.
- R3: On a miss, `nextAddr1` is the sampled fetch address with bits [1:0] cleared plus 4*GROUP_WORDS bytes (default 16), and `nextAddr2` is `nextAddr1` plus the same step. Both valid flags and both kinds are 0.
- R4: With a valid conditional first branch, `predFirst`=1 selects slot 0 (taken) and `predFirst`=0 selects slot 1 (fall-through) as `nextAddr1`.
- R5: The second-level descriptor is descriptor 1 when the first direction is taken and descriptor 2 otherwise. The two directions select `nextAddr2` as follows: taken/taken gives slot 2, taken/not gives slot 3, not/taken gives slot 4, not/not gives slot 5.
- R6: Kind codes are 0 conditional, 1 unconditional and 2 return. Kind 1 forces the taken direction at its level whatever the prediction says. Kinds 0 and 2 follow the prediction.
- R7: If descriptor 0 is invalid on a hit, `nextAddr1` and `nextAddr2` take the sequential values of R3, and `brValid1`, `brValid2` and both kinds are 0.
- R8: If the selected second-level descriptor is invalid, `nextAddr2` = `nextAddr1` + 4*GROUP_WORDS bytes, and `brValid2` and `brType2` are 0.
- R9: The index is address bits [IDX_W+1:2] and the tag is bits [31:IDX_W+2] (23 bits by default). Bits [1:0] are ignored. An address with the same index but a different tag misses.
- R10: A fill writes all fields of an entry at one edge. A lookup of that entry sampled at the same edge returns the previous contents, and a later fill replaces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| fetchAddr | input | 32 | Byte fetch address to look up |
| predFirst | input | 1 | Predicted direction of the first branch (1 = taken) |
| predSecond | input | 1 | Predicted direction of the second branch (1 = taken) |
| wrEn | input | 1 | Fill strobe |
| wrAddr | input | 32 | Fetch address that the filled entry belongs to |
| wrValid | input | 3 | Descriptor valid bits; bit k for descriptor k (0 first, 1 taken side, 2 fall-through side) |
| wrType | input | 6 | Descriptor kinds; bits [2k+1:2k] for descriptor k |
| wrTargets | input | 180 | Six 30-bit word addresses; slot k at bits [30k+29:30k] |
| hit | output | 1 | Tag matched a filled entry |
| brValid1 | output | 1 | A first branch was recorded |
| brValid2 | output | 1 | A second branch was recorded on the chosen side |
| brType1 | output | 2 | Kind of the first branch |
| brType2 | output | 2 | Kind of the chosen second branch |
| nextAddr1 | output | 32 | Byte address of the block after the current one |
| nextAddr2 | output | 32 | Byte address of the block after that |

## Verification
The bench walks all four prediction pairs over one entry. A swapped slot order or an inverted direction bit would therefore return the wrong one of the four second-level addresses. It plants an unconditional kind against an opposite prediction at each level, and clears descriptors one at a time. A design that obeyed the prediction, or fell through on the wrong descriptor, would give a target where a sequential address belongs. It also looks up an aliasing address with the same index and another tag, and it fills and reads one entry at the same edge. These catch a short tag compare and a write-through read that returns the new contents one cycle early.

// File: rtl/bac_pkg.sv
package bac_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFS_W   = 2;
  localparam int WADDR_W = ADDR_W - OFS_W;
  localparam int NDESC   = 3;
  localparam int NSLOT   = 6;
  localparam int KIND_W  = 2;
  localparam int TGT_W   = NSLOT * WADDR_W;
  localparam int DKIND_W = NDESC * KIND_W;

  // slot numbering: taken, fall-through, then the four two-level paths
  localparam int SLOT_T  = 0;
  localparam int SLOT_N  = 1;
  localparam int SLOT_TT = 2;

  typedef enum logic [KIND_W-1:0] {
    BR_COND = 2'd0,
    BR_JUMP = 2'd1,
    BR_RET  = 2'd2,
    BR_RSVD = 2'd3
  } brKind_e;

  // strobes handed from path control to the address datapath
  typedef struct packed {
    logic useFirst;   // first-level target comes from the entry
    logic useSecond;  // second-level target comes from the entry
    logic dirFirst;   // resolved first direction
    logic dirSecond;  // resolved second direction
  } pathStrb_t;
endpackage

// File: rtl/bac_table.sv
module bac_table
  import bac_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WADDR_W-1:0]   fetchWord,
  input  logic                 pred1,
  input  logic                 pred2,
  input  logic                 wrEn,
  input  logic [WADDR_W-1:0]   wrWord,
  input  logic [NDESC-1:0]     wrValid,
  input  logic [DKIND_W-1:0]   wrType,
  input  logic [TGT_W-1:0]     wrTargets,
  output logic                 rdHit,
  output logic [NDESC-1:0]     rdValid,
  output logic [DKIND_W-1:0]   rdType,
  output logic [TGT_W-1:0]     rdTargets,
  output logic [WADDR_W-1:0]   rdWord,
  output logic                 rdPred1,
  output logic                 rdPred2
);
  localparam int TAG_W = WADDR_W - IDX_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0]   tagMem  [DEPTH];
  logic [NDESC-1:0]   dvMem   [DEPTH];
  logic [DKIND_W-1:0] dkMem   [DEPTH];
  logic [TGT_W-1:0]   tgtMem  [DEPTH];
  logic [DEPTH-1:0]   entLive;

  logic [IDX_W-1:0] rIdx, wIdx;
  logic [TAG_W-1:0] rTag, wTag;

  assign rIdx = fetchWord[IDX_W-1:0];
  assign rTag = fetchWord[WADDR_W-1:IDX_W];
  assign wIdx = wrWord[IDX_W-1:0];
  assign wTag = wrWord[WADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) entLive <= '0;
    else if (wrEn) entLive[wIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn && rstN) begin
      tagMem[wIdx] <= wTag;
      dvMem[wIdx]  <= wrValid;
      dkMem[wIdx]  <= wrType;
      tgtMem[wIdx] <= wrTargets;
    end
  end

  // read sees the array as it stood before this edge's fill
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHit   <= 1'b0;
      rdValid <= '0;
    end else begin
      rdHit   <= entLive[rIdx] && (tagMem[rIdx] == rTag);
      rdValid <= dvMem[rIdx];
    end
  end

  always_ff @(posedge clk) begin
    rdType    <= dkMem[rIdx];
    rdTargets <= tgtMem[rIdx];
    rdWord    <= fetchWord;
    rdPred1   <= pred1;
    rdPred2   <= pred2;
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !rdHit);  // R1
endmodule

// File: rtl/bac_pathctl.sv
module bac_pathctl
  import bac_pkg::*;
(
  input  logic                 rdHit,
  input  logic [NDESC-1:0]     rdValid,
  input  logic [DKIND_W-1:0]   rdType,
  input  logic                 rdPred1,
  input  logic                 rdPred2,
  output pathStrb_t            strb,
  output logic [KIND_W-1:0]    kindFirst,
  output logic [KIND_W-1:0]    kindSecond
);
  brKind_e kinds [NDESC];

  for (genvar d = 0; d < NDESC; d++) begin : g_kind
    assign kinds[d] = brKind_e'(rdType[d*KIND_W +: KIND_W]);
  end

  logic    firstLive, dir1, dir2, sideValid;
  brKind_e sideKind;

  always_comb begin
    firstLive = rdHit && rdValid[0];
    dir1      = (kinds[0] == BR_JUMP) || rdPred1;
    sideValid = dir1 ? rdValid[1] : rdValid[2];
    sideKind  = dir1 ? kinds[1] : kinds[2];
    dir2      = (sideKind == BR_JUMP) || rdPred2;

    strb.useFirst  = firstLive;
    strb.useSecond = firstLive && sideValid;
    strb.dirFirst  = dir1;
    strb.dirSecond = dir2;

    kindFirst  = firstLive ? kinds[0] : BR_COND;
    kindSecond = (firstLive && sideValid) ? sideKind : BR_COND;
  end
endmodule

// File: rtl/bac_addrsel.sv
module bac_addrsel
  import bac_pkg::*;
#(
  parameter int GROUP_WORDS = 4
) (
  input  pathStrb_t            strb,
  input  logic [WADDR_W-1:0]   rdWord,
  input  logic [TGT_W-1:0]     rdTargets,
  output logic [ADDR_W-1:0]    next1,
  output logic [ADDR_W-1:0]    next2
);
  localparam logic [WADDR_W-1:0] STEP = WADDR_W'(GROUP_WORDS);

  logic [WADDR_W-1:0] slots [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slots[k] = rdTargets[k*WADDR_W +: WADDR_W];
  end

  logic [WADDR_W-1:0] w1, w2;
  logic [1:0]         pathSel;

  always_comb begin
    // taken/taken -> 0, taken/not -> 1, not/taken -> 2, not/not -> 3
    pathSel = {~strb.dirFirst, ~strb.dirSecond};
    if (strb.useFirst)
      w1 = strb.dirFirst ? slots[SLOT_T] : slots[SLOT_N];
    else
      w1 = rdWord + STEP;
    if (strb.useSecond)
      w2 = slots[SLOT_TT + int'(pathSel)];
    else
      w2 = w1 + STEP;
  end

  assign next1 = {w1, {OFS_W{1'b0}}};
  assign next2 = {w2, {OFS_W{1'b0}}};
endmodule

// File: rtl/bac_lookup.sv
module bac_lookup
  import bac_pkg::*;
#(
  parameter int IDX_W       = 7,
  parameter int GROUP_WORDS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [31:0]   fetchAddr,
  input  logic          predFirst,
  input  logic          predSecond,
  input  logic          wrEn,
  input  logic [31:0]   wrAddr,
  input  logic [2:0]    wrValid,
  input  logic [5:0]    wrType,
  input  logic [179:0]  wrTargets,
  output logic          hit,
  output logic          brValid1,
  output logic          brValid2,
  output logic [1:0]    brType1,
  output logic [1:0]    brType2,
  output logic [31:0]   nextAddr1,
  output logic [31:0]   nextAddr2
);
  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(GROUP_WORDS * 4);

  logic               rdHit, rdPred1, rdPred2;
  logic [NDESC-1:0]   rdValid;
  logic [DKIND_W-1:0] rdType;
  logic [TGT_W-1:0]   rdTargets;
  logic [WADDR_W-1:0] rdWord;
  pathStrb_t          strb;

  bac_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rstN(rstN),
    .fetchWord(fetchAddr[ADDR_W-1:OFS_W]),
    .pred1(predFirst), .pred2(predSecond),
    .wrEn(wrEn), .wrWord(wrAddr[ADDR_W-1:OFS_W]),
    .wrValid(wrValid), .wrType(wrType), .wrTargets(wrTargets),
    .rdHit(rdHit), .rdValid(rdValid), .rdType(rdType),
    .rdTargets(rdTargets), .rdWord(rdWord),
    .rdPred1(rdPred1), .rdPred2(rdPred2)
  );

  bac_pathctl u_ctl (
    .rdHit(rdHit), .rdValid(rdValid), .rdType(rdType),
    .rdPred1(rdPred1), .rdPred2(rdPred2),
    .strb(strb), .kindFirst(brType1), .kindSecond(brType2)
  );

  bac_addrsel #(.GROUP_WORDS(GROUP_WORDS)) u_sel (
    .strb(strb), .rdWord(rdWord), .rdTargets(rdTargets),
    .next1(nextAddr1), .next2(nextAddr2)
  );

  assign hit      = rdHit;
  assign brValid1 = strb.useFirst;
  assign brValid2 = strb.useSecond;

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(wrEn, 2) &&
     (($past(fetchAddr) >> 2) == ($past(wrAddr, 2) >> 2))) |-> hit);  // R2

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (!brValid1 && nextAddr1 == (($past(fetchAddr) & ~32'h3) + STEP_B)));  // R3

  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    brValid2 |-> (brValid1 && hit));  // R7

  AST_SECOND_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    !brValid2 |-> (nextAddr2 == nextAddr1 + STEP_B && brType2 == 2'd0));  // R8
endmodule

// File: tb/sim_bac_lookup.sv
`timescale 1ns/1ps
module sim_bac_lookup;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  fetchAddr = '0;
  logic         predFirst = 1'b0, predSecond = 1'b0;
  logic         wrEn = 1'b0;
  logic [31:0]  wrAddr = '0;
  logic [2:0]   wrValid = '0;
  logic [5:0]   wrType = '0;
  logic [179:0] wrTargets = '0;
  logic         hit, brValid1, brValid2;
  logic [1:0]   brType1, brType2;
  logic [31:0]  nextAddr1, nextAddr2;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  bac_lookup u0 (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr),
    .predFirst(predFirst), .predSecond(predSecond),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrValid(wrValid), .wrType(wrType),
    .wrTargets(wrTargets), .hit(hit), .brValid1(brValid1), .brValid2(brValid2),
    .brType1(brType1), .brType2(brType2),
    .nextAddr1(nextAddr1), .nextAddr2(nextAddr2)
  );

  localparam logic [31:0] A = 32'h1234_5670;

  function automatic logic [31:0] slotB(input logic [29:0] base, input int k);
    return {base + 30'(k * 16), 2'b00};
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic chk(input string req, input logic eh, input logic ev1, input logic ev2,
                     input logic [1:0] et1, input logic [1:0] et2,
                     input logic [31:0] en1, input logic [31:0] en2);
    nChecks++;
    if (hit !== eh || brValid1 !== ev1 || brValid2 !== ev2 || brType1 !== et1 ||
        brType2 !== et2 || nextAddr1 !== en1 || nextAddr2 !== en2) begin
      nFails++;
      $display("FAIL %s: got hit=%b v=%b%b t=%0d/%0d n1=%h n2=%h exp hit=%b v=%b%b t=%0d/%0d n1=%h n2=%h",
               req, hit, brValid1, brValid2, brType1, brType2, nextAddr1, nextAddr2,
               eh, ev1, ev2, et1, et2, en1, en2);
    end
  endtask

  task automatic fill(input logic [31:0] a, input logic [2:0] v, input logic [5:0] t,
                      input logic [29:0] base);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrValid = v; wrType = t;
    for (int k = 0; k < 6; k++) wrTargets[k*30 +: 30] = base + 30'(k * 16);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic p1, input logic p2);
    @(negedge clk);
    fetchAddr = a; predFirst = p1; predSecond = p2;
    @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1 in reset", 0, 0, 0, 0, 0, (fetchAddr & ~32'h3) + 16, (fetchAddr & ~32'h3) + 32);
    @(negedge clk); rstN = 1'b1;
    look(A, 1, 1);
    chk("R1 R3 miss after reset", 0, 0, 0, 0, 0, A + 16, A + 32);
    look(A | 32'h3, 0, 1);
    chk("R3 miss low bits", 0, 0, 0, 0, 0, A + 16, A + 32);
  endtask

  task automatic tPaths();
    fill(A, 3'b111, 6'b000000, 30'h1000);
    look(A, 1, 1); chk("R2 R5 taken/taken", 1, 1, 1, 0, 0, slotB(30'h1000, 0), slotB(30'h1000, 2));
    look(A, 1, 0); chk("R4 R5 taken/not", 1, 1, 1, 0, 0, slotB(30'h1000, 0), slotB(30'h1000, 3));
    look(A, 0, 1); chk("R4 R5 not/taken", 1, 1, 1, 0, 0, slotB(30'h1000, 1), slotB(30'h1000, 4));
    look(A, 0, 0); chk("R5 not/not", 1, 1, 1, 0, 0, slotB(30'h1000, 1), slotB(30'h1000, 5));
    look(A | 32'h2, 1, 1); chk("R9 offset ignored", 1, 1, 1, 0, 0, slotB(30'h1000, 0), slotB(30'h1000, 2));
  endtask

  task automatic tKinds();
    fill(A, 3'b111, 6'b001001, 30'h2000);   // d0 jump, d1 return, d2 cond
    look(A, 0, 0); chk("R6 first jump forced", 1, 1, 1, 1, 2, slotB(30'h2000, 0), slotB(30'h2000, 3));
    look(A, 0, 1); chk("R6 return follows pred", 1, 1, 1, 1, 2, slotB(30'h2000, 0), slotB(30'h2000, 2));
    fill(A, 3'b111, 6'b010000, 30'h3000);   // d0 cond, d1 cond, d2 jump
    look(A, 0, 0); chk("R6 second jump forced", 1, 1, 1, 0, 1, slotB(30'h3000, 1), slotB(30'h3000, 4));
  endtask

  task automatic tInvalid();
    fill(A, 3'b110, 6'b000000, 30'h4000);
    look(A, 1, 1); chk("R7 first invalid", 1, 0, 0, 0, 0, A + 16, A + 32);
    fill(A, 3'b101, 6'b100000, 30'h5000);   // d1 invalid, d2 return
    look(A, 1, 1); chk("R8 side invalid", 1, 1, 0, 0, 0, slotB(30'h5000, 0), slotB(30'h5000, 0) + 16);
    look(A, 0, 0); chk("R8 other side valid", 1, 1, 1, 0, 2, slotB(30'h5000, 1), slotB(30'h5000, 5));
  endtask

  task automatic tAlias();
    look(A + 32'h200, 1, 1);
    chk("R9 same index other tag", 0, 0, 0, 0, 0, A + 32'h210, A + 32'h220);
    look(A + 32'h4, 1, 1);
    chk("R9 neighbouring index", 0, 0, 0, 0, 0, A + 32'h14, A + 32'h24);
  endtask

  task automatic tSameEdge();
    logic [31:0] c = 32'h0ABC_0100;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = A; wrValid = 3'b111; wrType = 6'b0;
    for (int k = 0; k < 6; k++) wrTargets[k*30 +: 30] = 30'h6000 + 30'(k * 16);
    fetchAddr = A; predFirst = 1'b1; predSecond = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R10 same edge old data", 1, 1, 0, 0, 0, slotB(30'h5000, 0), slotB(30'h5000, 0) + 16);
    @(negedge clk);
    chk("R10 refill visible", 1, 1, 1, 0, 0, slotB(30'h6000, 0), slotB(30'h6000, 2));
    @(negedge clk);
    wrEn = 1'b1; wrAddr = c; wrValid = 3'b111;
    fetchAddr = c; predFirst = 1'b0; predSecond = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R10 fresh entry misses on fill edge", 0, 0, 0, 0, 0, c + 16, c + 32);
    @(negedge clk);
    chk("R10 fresh entry hits after", 1, 1, 1, 0, 0, slotB(30'h6000, 1), slotB(30'h6000, 5));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tPaths();
    tKinds();
    tInvalid();
    tAlias();
    tSameEdge();
    finishRun();
  end

  initial begin
    #(5.0 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout exp completion");
    finishRun();
  end
endmodule